// File: doc/BRIEF.md
# Closed Caption Byte Pair Gate

This block keeps two caption data bytes for each of two video fields and decides, once per field, whether the stored pair goes to the caption encoder. Software loads the bytes through a small write port. The address selects the field and the byte within the pair. A field-start strobe and a field index trigger the decision. In the cycle after that strobe the block presents a valid flag and the pair for that field. When nothing is sent, it presents a null filler byte.

Each field has its own enable. In free-running mode an enabled field resends its stored pair on every field start. In gated mode a field sends only after both of its bytes have been rewritten since its last transmission. A pair that is stale or only half written is therefore never sent again. A per-field pending output shows when a complete new pair is waiting.

Top module: `cc_pair_gate`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `cc_valid`=0, both byte outputs equal to `NULL_BYTE` (default 8'h80) and `pend`=0. Reset also sets every stored byte to `NULL_BYTE` and clears every written flag.
- R2: A write with `wr_en`=1 stores `wr_data` in one byte. `wr_addr[0]` selects the byte: 0 is the first byte and 1 is the second. `wr_addr[1]` selects the field: 0 is field 1 and 1 is field 2. The write also sets that byte's written flag.
- R3: A field start on a field whose bit in `cfg_en` is 0 gives `cc_valid`=0 in the next cycle and leaves both written flags of every field unchanged.
- R4: With `cfg_gate`=0, a field start on an enabled field gives `cc_valid`=1 in the next cycle. The outputs carry the stored first byte on `cc_byte1` and the stored second byte on `cc_byte2`, whether or not anything was written since the last send.
- R5: With `cfg_gate`=1, a field start on an enabled field whose two written flags are both set sends the pair as in R4. It then clears both flags of that field.
- R6: With `cfg_gate`=1, a field start on a field with fewer than two written flags set gives `cc_valid`=0 and keeps the flags. Once the missing byte is written, the next field start sends.
- R7: Whenever `cc_valid` is 0, `cc_byte1` and `cc_byte2` both equal `NULL_BYTE`.
- R8: `pend[i]` is 1 exactly when both written flags of field i+1 are set. A send in either mode clears the flags of the field that was sent.
- R9: `cc_valid` is high only in the cycle right after a cycle with `fld_start`=1.
- R10: When a write and a field start on the same field fall in the same cycle, the send uses the bytes stored before that write. The flag set by the write survives the send.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Bit 0: byte select; bit 1: field select |
| wr_data | input | 8 | Byte to store |
| cfg_en | input | 2 | Per-field caption enable (bit 0 is field 1) |
| cfg_gate | input | 1 | 1 selects gated mode |
| fld_start | input | 1 | Field-start strobe |
| fld_sel | input | 1 | Field starting: 0 is field 1, 1 is field 2 |
| cc_valid | output | 1 | Pair is sent this cycle |
| cc_byte1 | output | 8 | First byte, or null filler |
| cc_byte2 | output | 8 | Second byte, or null filler |
| pend | output | 2 | Per-field complete new pair waiting |

## Verification
The assertions assume that `fld_sel` names an existing field whenever `fld_start` is high. They also assume that `cfg_en` and `cfg_gate` hold steady across the cycle of a field start. The stimulus only changes the configuration right after a reset, and it only drives field indexes 0 and 1. For every combination of mode, enable mask, target field and partial write pattern, the stimulus issues repeated field starts. This shows the stale-pair suppression, the resend in free-running mode, and the completion of a half-written pair.

// File: rtl/cc_gate_pkg.sv
package cc_gate_pkg;
  // Byte position inside a field's pair, as decoded from the write address LSB
  typedef enum logic {
    PAIR_FIRST  = 1'b0,
    PAIR_SECOND = 1'b1
  } pair_pos_e;
endpackage

// File: rtl/cc_field_slot.sv
module cc_field_slot #(
  parameter int unsigned          BYTE_W    = 8,
  parameter logic [BYTE_W-1:0]    NULL_BYTE = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_first,
  input  logic              wr_second,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              consume,
  output logic [BYTE_W-1:0] byte_first,
  output logic [BYTE_W-1:0] byte_second,
  output logic              have_first,
  output logic              have_second
);
  always_ff @(posedge clk) begin
    if (rst) begin
      byte_first  <= NULL_BYTE;
      byte_second <= NULL_BYTE;
      have_first  <= 1'b0;
      have_second <= 1'b0;
    end else begin
      if (wr_first)  byte_first  <= wr_data;
      if (wr_second) byte_second <= wr_data;
      // a send clears the flags; a write in the same cycle re-arms its own flag
      have_first  <= (have_first  & ~consume) | wr_first;
      have_second <= (have_second & ~consume) | wr_second;
    end
  end
endmodule

// File: rtl/cc_send_dec.sv
module cc_send_dec #(
  parameter int unsigned NUM_FIELDS = 2,
  parameter int unsigned FLD_W      = 1
) (
  input  logic                  fld_start,
  input  logic [FLD_W-1:0]      fld_sel,
  input  logic [NUM_FIELDS-1:0] cfg_en,
  input  logic                  cfg_gate,
  input  logic [NUM_FIELDS-1:0] have_first,
  input  logic [NUM_FIELDS-1:0] have_second,
  output logic                  send,
  output logic [NUM_FIELDS-1:0] consume
);
  logic in_range;
  logic complete;

  always_comb begin
    in_range = (32'(fld_sel) < NUM_FIELDS);
    complete = 1'b0;
    send     = 1'b0;
    consume  = '0;
    if (in_range) begin
      complete = have_first[fld_sel] & have_second[fld_sel];
      send     = fld_start & cfg_en[fld_sel] & (~cfg_gate | complete);
      if (send) consume[fld_sel] = 1'b1;
    end
  end
endmodule

// File: rtl/cc_pair_gate.sv
module cc_pair_gate #(
  parameter int unsigned       BYTE_W     = 8,
  parameter int unsigned       NUM_FIELDS = 2,
  parameter logic [BYTE_W-1:0] NULL_BYTE  = 8'h80,
  localparam int unsigned      FLD_W      = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int unsigned      ADDR_W     = FLD_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [BYTE_W-1:0]     wr_data,
  input  logic [NUM_FIELDS-1:0] cfg_en,
  input  logic                  cfg_gate,
  input  logic                  fld_start,
  input  logic [FLD_W-1:0]      fld_sel,
  output logic                  cc_valid,
  output logic [BYTE_W-1:0]     cc_byte1,
  output logic [BYTE_W-1:0]     cc_byte2,
  output logic [NUM_FIELDS-1:0] pend
);
  import cc_gate_pkg::*;

  logic [NUM_FIELDS-1:0] have_first;
  logic [NUM_FIELDS-1:0] have_second;
  logic [NUM_FIELDS-1:0] consume;
  logic [BYTE_W-1:0]     slot_first  [NUM_FIELDS];
  logic [BYTE_W-1:0]     slot_second [NUM_FIELDS];
  logic                  send;
  logic [FLD_W-1:0]      wr_field;
  pair_pos_e             wr_pos;

  assign wr_field = wr_addr[ADDR_W-1:1];
  assign wr_pos   = pair_pos_e'(wr_addr[0]);

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_slot
    logic hit;
    assign hit = wr_en & (32'(wr_field) == f);

    cc_field_slot #(
      .BYTE_W   (BYTE_W),
      .NULL_BYTE(NULL_BYTE)
    ) u_slot (
      .clk        (clk),
      .rst        (rst),
      .wr_first   (hit & (wr_pos == PAIR_FIRST)),
      .wr_second  (hit & (wr_pos == PAIR_SECOND)),
      .wr_data    (wr_data),
      .consume    (consume[f]),
      .byte_first (slot_first[f]),
      .byte_second(slot_second[f]),
      .have_first (have_first[f]),
      .have_second(have_second[f])
    );
  end

  cc_send_dec #(
    .NUM_FIELDS(NUM_FIELDS),
    .FLD_W     (FLD_W)
  ) u_dec (
    .fld_start  (fld_start),
    .fld_sel    (fld_sel),
    .cfg_en     (cfg_en),
    .cfg_gate   (cfg_gate),
    .have_first (have_first),
    .have_second(have_second),
    .send       (send),
    .consume    (consume)
  );

  assign pend = have_first & have_second;

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_valid <= 1'b0;
      cc_byte1 <= NULL_BYTE;
      cc_byte2 <= NULL_BYTE;
    end else begin
      cc_valid <= send;
      if (send) begin
        cc_byte1 <= slot_first[fld_sel];
        cc_byte2 <= slot_second[fld_sel];
      end else begin
        cc_byte1 <= NULL_BYTE;
        cc_byte2 <= NULL_BYTE;
      end
    end
  end
endmodule

// File: rtl/cc_pair_gate_chk.sv
module cc_pair_gate_chk #(
  parameter int unsigned       BYTE_W     = 8,
  parameter int unsigned       NUM_FIELDS = 2,
  parameter logic [BYTE_W-1:0] NULL_BYTE  = 8'h80,
  parameter int unsigned       FLD_W      = 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_FIELDS-1:0] cfg_en,
  input logic                  cfg_gate,
  input logic                  fld_start,
  input logic [FLD_W-1:0]      fld_sel,
  input logic                  cc_valid,
  input logic [BYTE_W-1:0]     cc_byte1,
  input logic [BYTE_W-1:0]     cc_byte2,
  input logic [NUM_FIELDS-1:0] pend
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!cc_valid && pend == '0 && cc_byte1 == NULL_BYTE));

  assert_only_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    cc_valid |-> $past(cfg_en[fld_sel]));

  assert_gate_sends_R5: assert property (@(posedge clk) disable iff (rst)
    (fld_start && cfg_gate && cfg_en[fld_sel] && pend[fld_sel]) |=> cc_valid);

  assert_gate_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (fld_start && cfg_gate && !pend[fld_sel]) |=> !cc_valid);

  assert_free_sends_R4: assert property (@(posedge clk) disable iff (rst)
    (fld_start && !cfg_gate && cfg_en[fld_sel]) |=> cc_valid);

  assert_null_fill_R7: assert property (@(posedge clk) disable iff (rst)
    !cc_valid |-> (cc_byte1 == NULL_BYTE && cc_byte2 == NULL_BYTE));

  assert_pulse_after_start_R9: assert property (@(posedge clk) disable iff (rst)
    cc_valid |-> $past(fld_start));
endmodule

bind cc_pair_gate cc_pair_gate_chk #(
  .BYTE_W    (BYTE_W),
  .NUM_FIELDS(NUM_FIELDS),
  .NULL_BYTE (NULL_BYTE),
  .FLD_W     (FLD_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_en   (cfg_en),
  .cfg_gate (cfg_gate),
  .fld_start(fld_start),
  .fld_sel  (fld_sel),
  .cc_valid (cc_valid),
  .cc_byte1 (cc_byte1),
  .cc_byte2 (cc_byte2),
  .pend     (pend)
);

// File: tb/cc_pair_gate_bench.sv
module cc_pair_gate_bench;
  localparam logic [7:0] NUL = 8'h80;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_en = '0;
  logic       cfg_gate = 1'b0;
  logic       fld_start = 1'b0;
  logic       fld_sel = 1'b0;
  logic       cc_valid;
  logic [7:0] cc_byte1, cc_byte2;
  logic [1:0] pend;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state: [field][byte]
  logic [7:0] m_b [2][2];
  bit         m_f [2][2];

  always #2.5 clk = ~clk;

  cc_pair_gate u_cc_pair_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_en(cfg_en), .cfg_gate(cfg_gate), .fld_start(fld_start), .fld_sel(fld_sel),
    .cc_valid(cc_valid), .cc_byte1(cc_byte1), .cc_byte2(cc_byte2), .pend(pend)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_pend(input string req);
    logic [1:0] e;
    e = {m_f[1][0] & m_f[1][1], m_f[0][0] & m_f[0][1]};
    chk(pend == e, req, int'(pend), int'(e));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int f = 0; f < 2; f++)
      for (int b = 0; b < 2; b++) begin
        m_b[f][b] = NUL;
        m_f[f][b] = 0;
      end
    chk(!cc_valid && cc_byte1 == NUL && cc_byte2 == NUL && pend == 2'b00, "R1",
        int'({cc_valid, cc_byte1, cc_byte2, pend}), int'({1'b0, NUL, NUL, 2'b00}));
  endtask

  task automatic wr(input int f, input int b, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {f[0], b[0]}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_b[f][b] = d;
    m_f[f][b] = 1;
  endtask

  // field start, optionally with a simultaneous write to (f, wb)
  task automatic start(input int f, input bit with_wr, input int wb, input logic [7:0] d,
                       input string req);
    bit send;
    logic [7:0] e1, e2;
    @(negedge clk);
    fld_start = 1'b1; fld_sel = f[0];
    if (with_wr) begin
      wr_en = 1'b1; wr_addr = {f[0], wb[0]}; wr_data = d;
    end
    send = cfg_en[f] && (!cfg_gate || (m_f[f][0] && m_f[f][1]));
    e1 = send ? m_b[f][0] : NUL;
    e2 = send ? m_b[f][1] : NUL;
    if (send) begin
      m_f[f][0] = 0;
      m_f[f][1] = 0;
    end
    if (with_wr) begin
      m_b[f][wb] = d;
      m_f[f][wb] = 1;
    end
    @(negedge clk);
    fld_start = 1'b0; wr_en = 1'b0;
    chk(cc_valid == send, req, int'(cc_valid), int'(send));
    chk(cc_byte1 == e1 && cc_byte2 == e2, send ? req : "R7",
        int'({cc_byte1, cc_byte2}), int'({e1, e2}));
    chk_pend("R8");
    @(negedge clk);
    chk(!cc_valid, "R9", int'(cc_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < 2; g++)
      for (int en = 0; en < 4; en++)
        for (int pat = 0; pat < 4; pat++)
          for (int f = 0; f < 2; f++) begin
            string rq;
            do_reset();
            cfg_gate = g[0];
            cfg_en = en[1:0];
            rq = !en[f] ? "R3" : (g == 0 ? "R4" : (pat == 3 ? "R5" : "R6"));
            // the other field gets a full pair (R2)
            wr(1 - f, 0, 8'(8'h40 + 16 * pat + f));
            wr(1 - f, 1, 8'(8'h50 + 16 * pat + f));
            if (pat[0]) wr(f, 0, 8'(8'h11 + 16 * pat + 2 * en + g));
            if (pat[1]) wr(f, 1, 8'(8'h22 + 16 * pat + 2 * en + g));
            chk_pend("R2");
            start(f, 0, 0, 8'h00, rq);
            // second start: free mode resends stale pair, gated mode must not (R5)
            start(f, 0, 0, 8'h00, g == 0 ? "R4" : "R5");
            // complete any missing byte, then send (R6)
            if (!pat[0]) wr(f, 0, 8'(8'h33 + en));
            if (!pat[1]) wr(f, 1, 8'(8'h44 + en));
            start(f, 0, 0, 8'h00, "R6");
            // other field still holds its pair and flags unless enabled and sent
            start(1 - f, 0, 0, 8'h00, "R3");
          end

    // R10: write and start on same field in one cycle
    for (int g = 0; g < 2; g++) begin
      do_reset();
      cfg_gate = g[0];
      cfg_en = 2'b11;
      wr(1, 0, 8'hA1);
      wr(1, 1, 8'hB2);
      start(1, 1, 0, 8'hC3, "R10");
      chk_pend("R10");
      wr(1, 1, 8'hD4);
      start(1, 0, 0, 8'h00, "R10");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule